// File: doc/BRIEF.md
# Counter Freeze and Management-Mode Save/Restore Controller

This block owns two live registers: a global counter-enable vector with one bit per performance counter, and a debug-control word. Software loads either register through a simple write port. Two kinds of hardware event also change them.

- **Performance-monitor interrupt.** When freeze-on-interrupt is enabled, an interrupt request clears every counter enable in one cycle.
- **Management-mode entry.** This is honoured only when the freeze-in-management-mode control is set and the capability strap reports support. On entry the block clears all counter enables. It saves the debug-control word to a shadow register, then clears four tracing fields in the live word.
- **Resume.** A resume strobe sets every counter enable and copies the shadow back into the live debug-control word.

The block tracks whether it is inside management mode. A second entry strobe while inside is ignored, so the shadow cannot be overwritten. Software writes made while inside change only the live registers, and the resume restore then replaces the debug-control word. When an event and a software write land in the same cycle, the write is applied first and the event then acts on the result.

Top module: `pmon_freeze_ctl`

## Requirements
- R1: After reset, `cnt_enable` is all zeros, `dbg_ctl` is zero, and the block is outside management mode.
- R2: A software write strobe loads its data into the matching live register, visible on the output one clock later.
- R3: A `pmi_req` with `frz_pmi_en` high clears every bit of `cnt_enable` in the next cycle. With `frz_pmi_en` low, `pmi_req` has no effect.
- R4: A management entry (`smi_strobe` while outside management mode, with freeze-in-management-mode active) clears every bit of `cnt_enable` in the next cycle.
- R5: On that entry the debug word is saved to the shadow. The live word loses bit 0 (record enable), bit 1 (branch single-step), bit 6 (trace message) and bit 7 (branch store); all other bits are kept.
- R6: `rsm_strobe` while inside management mode sets every bit of `cnt_enable` and restores `dbg_ctl` from the shadow, then leaves management mode.
- R7: Freeze-in-management-mode is active only when both `frz_smm_en` and `cap_frz_smm` are 1. Otherwise `smi_strobe` and `rsm_strobe` leave both registers unchanged.
- R8: An `smi_strobe` while already inside management mode is ignored. The live registers hold, and the shadow keeps the first saved value, which the next resume shows on `dbg_ctl`.
- R9: Software writes inside management mode change only the live registers. On resume, `dbg_ctl` takes the shadow value regardless of those writes.
- R10: In the same cycle, a software write applies first and the entry, resume or interrupt freeze then overrides it. An interrupt freeze overrides a resume's enable set. An entry saves the value just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smi_strobe | input | 1 | Management interrupt delivered |
| rsm_strobe | input | 1 | Resume from management mode |
| pmi_req | input | 1 | Performance-monitor interrupt request |
| frz_pmi_en | input | 1 | Freeze counters on interrupt |
| frz_smm_en | input | 1 | Freeze while in management mode |
| cap_frz_smm | input | 1 | Capability strap for the management-mode freeze |
| sw_en_we | input | 1 | Software write of the enable vector |
| sw_en_wdata | input | NCNT | Enable vector write data |
| sw_dbg_we | input | 1 | Software write of debug control |
| sw_dbg_wdata | input | DW | Debug control write data |
| cnt_enable | output | NCNT | Live global counter enables |
| dbg_ctl | output | DW | Live debug-control word |

## Verification
The bench sweeps every combination of the three configuration inputs against every combination of the three event strobes and both write strobes, in both management states, and checks each cycle against an arithmetic model. Several mistakes would show up here. A design that honoured the management-mode freeze without the capability strap would zero the enables when it should hold them. A design that let a nested entry re-save would bring back a cleared debug word on resume. A design that let software writes reach the shadow would restore the wrong word. Getting the same-cycle ordering wrong would show as a surviving write value, or as an all-ones vector where a freeze should have won.

// File: rtl/pmon_freeze_ctl.sv
module pmon_freeze_ctl #(
  parameter int NCNT      = 4,
  parameter int DW        = 16,
  parameter int TRC_BIT   = 6,
  parameter int STORE_BIT = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smi_strobe,
  input  logic            rsm_strobe,
  input  logic            pmi_req,
  input  logic            frz_pmi_en,
  input  logic            frz_smm_en,
  input  logic            cap_frz_smm,
  input  logic            sw_en_we,
  input  logic [NCNT-1:0] sw_en_wdata,
  input  logic            sw_dbg_we,
  input  logic [DW-1:0]   sw_dbg_wdata,
  output logic [NCNT-1:0] cnt_enable,
  output logic [DW-1:0]   dbg_ctl
);
  localparam logic [DW-1:0] CLR_MASK =
    (DW'(1) << 0) | (DW'(1) << 1) | (DW'(1) << TRC_BIT) | (DW'(1) << STORE_BIT);

  logic          in_smm;
  logic [DW-1:0] shadow;

  wire smm_on = frz_smm_en & cap_frz_smm;
  wire enter  = smi_strobe & smm_on & ~in_smm;
  wire leave  = rsm_strobe & in_smm;
  wire freeze = pmi_req & frz_pmi_en;

  wire [NCNT-1:0] en_sw  = sw_en_we  ? sw_en_wdata  : cnt_enable;
  wire [DW-1:0]   dbg_sw = sw_dbg_we ? sw_dbg_wdata : dbg_ctl;

  logic [NCNT-1:0] en_nx;
  logic [DW-1:0]   dbg_nx;

  always_comb begin
    en_nx  = en_sw;
    dbg_nx = dbg_sw;
    if (enter) begin
      en_nx  = '0;
      dbg_nx = dbg_sw & ~CLR_MASK;
    end else if (leave) begin
      en_nx  = '1;
      dbg_nx = shadow;
    end
    if (freeze) en_nx = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_enable <= '0;
      dbg_ctl    <= '0;
      shadow     <= '0;
      in_smm     <= 1'b0;
    end else begin
      cnt_enable <= en_nx;
      dbg_ctl    <= dbg_nx;
      if (enter) shadow <= dbg_sw;
      if (enter)      in_smm <= 1'b1;
      else if (leave) in_smm <= 1'b0;
    end
  end
endmodule

module pmon_freeze_chk #(
  parameter int NCNT      = 4,
  parameter int DW        = 16,
  parameter int TRC_BIT   = 6,
  parameter int STORE_BIT = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            smi_strobe,
  input logic            rsm_strobe,
  input logic            pmi_req,
  input logic            frz_pmi_en,
  input logic            frz_smm_en,
  input logic            cap_frz_smm,
  input logic            sw_en_we,
  input logic            sw_dbg_we,
  input logic            in_smm,
  input logic [NCNT-1:0] cnt_enable,
  input logic [DW-1:0]   dbg_ctl
);
  localparam logic [DW-1:0] CLR_MASK =
    (DW'(1) << 0) | (DW'(1) << 1) | (DW'(1) << TRC_BIT) | (DW'(1) << STORE_BIT);

  assert_pmi_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pmi_req && frz_pmi_en) |=> (cnt_enable == '0));

  assert_entry_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_strobe && frz_smm_en && cap_frz_smm && !in_smm) |=> (cnt_enable == '0) && in_smm);

  assert_entry_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_strobe && frz_smm_en && cap_frz_smm && !in_smm) |=> ((dbg_ctl & CLR_MASK) == '0));

  assert_resume_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsm_strobe && in_smm && !(pmi_req && frz_pmi_en)) |=> (&cnt_enable) && !in_smm);

  assert_gate_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_smm && !(frz_smm_en && cap_frz_smm) && !sw_en_we && !sw_dbg_we && !pmi_req)
      |=> $stable(cnt_enable) && $stable(dbg_ctl) && !in_smm);

  assert_nested_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_smm && smi_strobe && !rsm_strobe && !sw_dbg_we) |=> $stable(dbg_ctl) && in_smm);
endmodule

bind pmon_freeze_ctl pmon_freeze_chk #(
  .NCNT(NCNT), .DW(DW), .TRC_BIT(TRC_BIT), .STORE_BIT(STORE_BIT)
) u_chk (.*);

// File: tb/tb_pmon_freeze_ctl.sv
`timescale 1ns/1ps
module tb_pmon_freeze_ctl;
  localparam int NCNT = 4;
  localparam int DW   = 16;
  localparam logic [DW-1:0] CLRM = 16'h00C3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic smi = 0, rsm = 0, pmi = 0, fpmi = 0, fsmm = 0, cap = 0;
  logic ewe = 0, dwe = 0;
  logic [NCNT-1:0] ed = '0;
  logic [DW-1:0]   dd = '0;
  logic [NCNT-1:0] cnt_enable;
  logic [DW-1:0]   dbg_ctl;

  int total = 0, bad = 0;
  bit done = 0;

  logic [NCNT-1:0] m_en;
  logic [DW-1:0]   m_dbg, m_sh;
  bit              m_in;

  always #2 clk = ~clk;

  pmon_freeze_ctl dut (
    .clk(clk), .rst_n(rst_n), .smi_strobe(smi), .rsm_strobe(rsm), .pmi_req(pmi),
    .frz_pmi_en(fpmi), .frz_smm_en(fsmm), .cap_frz_smm(cap),
    .sw_en_we(ewe), .sw_en_wdata(ed), .sw_dbg_we(dwe), .sw_dbg_wdata(dd),
    .cnt_enable(cnt_enable), .dbg_ctl(dbg_ctl));

  task automatic chk(string tag);
    total++;
    if (cnt_enable !== m_en) begin
      bad++;
      $display("FAIL %s enable: got %h want %h", tag, cnt_enable, m_en);
    end
    total++;
    if (dbg_ctl !== m_dbg) begin
      bad++;
      $display("FAIL %s debug: got %h want %h", tag, dbg_ctl, m_dbg);
    end
  endtask

  task automatic step(bit s, bit r, bit p, bit we, logic [NCNT-1:0] e, bit wd, logic [DW-1:0] d);
    string tag;
    bit on, ent, lv;
    logic [NCNT-1:0] en1;
    logic [DW-1:0] db1;
    smi = s; rsm = r; pmi = p; ewe = we; ed = e; dwe = wd; dd = d;
    on  = fsmm && cap;
    ent = s && on && !m_in;
    lv  = r && m_in;
    en1 = we ? e : m_en;
    db1 = wd ? d : m_dbg;
    if (ent) begin
      m_sh = db1; m_in = 1; en1 = '0; db1 = db1 & ~CLRM;
    end else if (lv) begin
      m_in = 0; en1 = '1; db1 = m_sh;
    end
    if (p && fpmi) en1 = '0;
    m_en = en1; m_dbg = db1;
    if ((we || wd) && (ent || lv || (p && fpmi))) tag = "R10";
    else if (p && fpmi) tag = "R3";
    else if (ent) tag = "R5";
    else if (lv && m_sh != 0) tag = "R9";
    else if (lv) tag = "R6";
    else if (s && m_in) tag = "R8";
    else if ((s || r) && !on) tag = "R7";
    else if (we || wd) tag = "R2";
    else tag = "R4";
    @(negedge clk);
    smi = 0; rsm = 0; pmi = 0; ewe = 0; dwe = 0;
    chk(tag);
  endtask

  initial begin
    #800000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_en = '0; m_dbg = '0; m_sh = '0; m_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1");
    for (int cfg = 0; cfg < 8; cfg++) begin
      fpmi = cfg[0]; fsmm = cfg[1]; cap = cfg[2];
      // R4 R5: a clean entry with all tracing fields set, then R8 nested, R9 write, R6 resume
      step(0, 0, 0, 1, 4'hA, 1, 16'hF0FF);
      step(1, 0, 0, 0, '0, 0, '0);
      step(1, 0, 0, 0, '0, 0, '0);
      step(0, 0, 0, 1, 4'h5, 1, 16'h1234);
      step(0, 1, 0, 0, '0, 0, '0);
      step(0, 0, 1, 0, '0, 0, '0);
      for (int rnd = 0; rnd < 2; rnd++)
        for (int c = 0; c < 32; c++) begin
          logic [NCNT-1:0] ev;
          logic [DW-1:0] dv;
          ev = NCNT'(c * 3 + rnd + cfg);
          dv = DW'((c * 16'h2F1B) ^ (cfg * 16'h0C31) ^ (rnd * 16'h8000));
          step(c[0], c[1], c[2], c[3], ev, c[4], dv);
        end
      step(0, 1, 0, 0, '0, 0, '0);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule